// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

This block keeps time as a seconds count plus a millisecond count. A
millisecond enable, made from a slow reference clock outside the block,
moves the millisecond field on by one each time it is asserted. When the
field passes its last value it returns to zero and the seconds count goes
up by one. The counter is meant to stay powered and keep running while the
rest of the system sleeps. Software reads it as a system time base.

Software reads the time through a small register port. Reading the
milliseconds register also copies the live seconds into a separate
snapshot register in the same cycle. Software therefore reads milliseconds
first and then the snapshot. The pair it gets is always consistent, even
if a seconds rollover falls between the two reads. The combined time is
snapshot × 1000 + milliseconds. It goes up 1000 times a second and is
treated as a wrapping 32-bit number.

Top module: `ms_rtc_top`

## Requirements
- R1: After reset the live seconds, milliseconds and snapshot registers all read as zero.
- R2: Each cycle with `tick_ms` high moves the millisecond count on by one. A cycle without it leaves both seconds and milliseconds unchanged.
- R3: The millisecond count stays within 0 to 999. A tick at 999 sets it to 0 and adds one to seconds.
- R4: Seconds is a 32-bit count that wraps from 0xFFFFFFFF to 0.
- R5: A read at byte offset 0x10 returns the milliseconds value on `bus_rdata` one cycle later. In the same clock edge it loads the snapshot register with the live seconds.
- R6: A read at offset 0x0C returns the snapshot. The snapshot changes only on a milliseconds read, so ticks, other reads and writes leave it unchanged.
- R7: A write to offset 0x08 loads seconds from `bus_wdata` and clears milliseconds. It takes priority over a tick in the same cycle.
- R8: Writes to offsets 0x0C and 0x10 have no effect.
- R9: A read at 0x08 returns the live seconds. A read at any unmapped offset returns zero.
- R10: A milliseconds read followed by a snapshot read gives the seconds and milliseconds of the same moment, including at a rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond enable |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |

## Verification
On every cycle the assertions check the following:
- the millisecond range, the step on each tick and the hold without one;
- seconds carry at 999;
- write loading and its priority over a tick;
- snapshot capture on a milliseconds read and hold otherwise;
- the one-cycle read data for milliseconds.

Only the bench scenarios can show the following:
- that the pair from milliseconds-then-snapshot is coherent across a rollover;
- that writes to the read-only offsets leave nothing changed;
- the 32-bit seconds wrap;
- zero returned from unmapped offsets.

// File: rtl/rtc_ms_pkg.sv
package rtc_ms_pkg;
   // Byte offsets decoded by software; their values are part of the interface.
   localparam int unsigned OFS_SECONDS  = 32'h08;
   localparam int unsigned OFS_SNAPSHOT = 32'h0C;
   localparam int unsigned OFS_MILLIS   = 32'h10;

   typedef enum logic [1:0] {
      REG_NONE,
      REG_SECONDS,
      REG_SNAPSHOT,
      REG_MILLIS
   } rtc_reg_e;
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
   import rtc_ms_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output rtc_reg_e          reg_sel
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("rtc_addr_decode: ADDR_W too small for register offsets");
   end

   always_comb begin
      if (addr == ADDR_W'(OFS_SECONDS))       reg_sel = REG_SECONDS;
      else if (addr == ADDR_W'(OFS_SNAPSHOT)) reg_sel = REG_SNAPSHOT;
      else if (addr == ADDR_W'(OFS_MILLIS))   reg_sel = REG_MILLIS;
      else                                    reg_sel = REG_NONE;
   end
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
   parameter int SEC_W      = 32,
   parameter int MS_PER_SEC = 1000,
   parameter int MS_W       = $clog2(MS_PER_SEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   output logic [MS_W-1:0]  ms_q,
   output logic [SEC_W-1:0] sec_q
);
   localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

   if (MS_PER_SEC < 2) begin : g_bad_rate
      $error("rtc_time_count: MS_PER_SEC must be at least 2");
   end

   logic ms_wrap;
   assign ms_wrap = (ms_q == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_q  <= '0;
         sec_q <= '0;
      end else if (load) begin
         ms_q  <= '0;
         sec_q <= load_val;
      end else if (tick) begin
         if (ms_wrap) begin
            ms_q  <= '0;
            sec_q <= sec_q + 1'b1;
         end else begin
            ms_q  <= ms_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_shadow_latch.sv
module rtc_shadow_latch #(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [SEC_W-1:0] sec_in,
   output logic [SEC_W-1:0] shadow_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shadow_q <= '0;
      else if (capture) shadow_q <= sec_in;
   end
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
   import rtc_ms_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEC_W     = 32,
   parameter int MS_W      = 10,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  rtc_reg_e          reg_sel,
   input  logic [SEC_W-1:0]  sec,
   input  logic [SEC_W-1:0]  shadow,
   input  logic [MS_W-1:0]   ms,
   output logic [DATA_W-1:0] rdata
);
   if (DATA_W < SEC_W || DATA_W < MS_W) begin : g_bad_data
      $error("rtc_read_port: DATA_W narrower than a register");
   end

   logic [DATA_W-1:0] mux_d;

   always_comb begin
      mux_d = '0;
      if (rd) begin
         unique case (reg_sel)
            REG_SECONDS:  mux_d = DATA_W'(sec);
            REG_SNAPSHOT: mux_d = DATA_W'(shadow);
            REG_MILLIS:   mux_d = DATA_W'(ms);
            default:      mux_d = '0;
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rdata <= '0;
         else if (rd) rdata <= mux_d;
      end
   end else begin : g_rd_comb
      assign rdata = mux_d;
   end
endmodule

// File: rtl/ms_rtc_top.sv
module ms_rtc_top
   import rtc_ms_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 32,
   parameter int MS_PER_SEC = 1000,
   parameter bit RDATA_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int MS_W = $clog2(MS_PER_SEC);

   rtc_reg_e         reg_sel;
   logic             rd_req, wr_req, load_sec, cap_shadow;
   logic [MS_W-1:0]  ms_q;
   logic [SEC_W-1:0] sec_q, shadow_q;

   assign rd_req     = bus_sel & ~bus_we;
   assign wr_req     = bus_sel &  bus_we;
   assign load_sec   = wr_req & (reg_sel == REG_SECONDS);
   assign cap_shadow = rd_req & (reg_sel == REG_MILLIS);

   rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (bus_addr),
      .reg_sel (reg_sel)
   );

   rtc_time_count #(.SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .load     (load_sec),
      .load_val (bus_wdata[SEC_W-1:0]),
      .ms_q     (ms_q),
      .sec_q    (sec_q)
   );

   rtc_shadow_latch #(.SEC_W(SEC_W)) u_shd (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (cap_shadow),
      .sec_in   (sec_q),
      .shadow_q (shadow_q)
   );

   rtc_read_port #(.DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W),
                   .RDATA_REG(RDATA_REG)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (rd_req),
      .reg_sel (reg_sel),
      .sec     (sec_q),
      .shadow  (shadow_q),
      .ms      (ms_q),
      .rdata   (bus_rdata)
   );
endmodule

// File: rtl/ms_rtc_chk.sv
module ms_rtc_chk #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 32,
   parameter int MS_PER_SEC = 1000,
   parameter bit RDATA_REG  = 1'b1,
   parameter int MS_W       = $clog2(MS_PER_SEC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              sel,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [MS_W-1:0]   ms,
   input logic [SEC_W-1:0]  sec,
   input logic [SEC_W-1:0]  shadow
);
   localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

   logic wr_s, rd_m;
   assign wr_s = sel & we & (addr == ADDR_W'(8'h08));
   assign rd_m = sel & ~we & (addr == ADDR_W'(8'h10));

   assert_ms_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ms <= LAST);

   assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_s && ms != LAST) |=> ms == MS_W'($past(ms) + 1'b1));

   assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_s && ms == LAST) |=> (ms == '0) && (sec == SEC_W'($past(sec) + 1'b1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_s) |=> $stable(ms) && $stable(sec));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_s |=> (sec == $past(wdata[SEC_W-1:0])) && (ms == '0));

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_m |=> shadow == $past(sec));

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_m |=> $stable(shadow));

   assert_ms_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (RDATA_REG && rd_m) |=> rdata == DATA_W'($past(ms)));
endmodule

bind ms_rtc_top ms_rtc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W),
   .MS_PER_SEC(MS_PER_SEC), .RDATA_REG(RDATA_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_ms), .sel(bus_sel), .we(bus_we),
   .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
   .ms(ms_q), .sec(sec_q), .shadow(shadow_q)
);

// File: tb/ms_rtc_top_tb.sv
module ms_rtc_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ms = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0, errors = 0;
   logic [31:0] m_sec = '0, m_sh = '0;
   int unsigned m_ms = 0;

   always #2 clk = ~clk;

   ms_rtc_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h08:   return m_sec;
         8'h0C:   return m_sh;
         8'h10:   return 32'(m_ms);
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic step(input logic sel, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic tk, input string req);
      logic [31:0] exp;
      @(negedge clk);
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; tick_ms = tk;
      exp = model_read(a);
      if (sel && !we && a == 8'h10) m_sh = m_sec;
      if (sel && we && a == 8'h08) begin
         m_sec = d; m_ms = 0;
      end else if (tk) begin
         if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
         else m_ms = m_ms + 1;
      end
      @(posedge clk); #1;
      if (sel && !we) check(req, bus_rdata, exp);
   endtask

   task automatic idle(input int n, input logic tk);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0, tk, "");
   endtask

   initial begin
      #800000;
      checks++; errors++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      // R1: all registers zero after reset
      step(1, 0, 8'h0C, 0, 0, "R1 snapshot");
      step(1, 0, 8'h08, 0, 0, "R1 seconds");
      step(1, 0, 8'h10, 0, 0, "R1 millis");
      // R2: ticks advance, idle holds
      idle(7, 1'b1);
      step(1, 0, 8'h10, 0, 0, "R2 after 7 ticks");
      idle(5, 1'b0);
      step(1, 0, 8'h10, 0, 0, "R2 hold without tick");
      // R7: write wins over tick
      step(1, 1, 8'h08, 32'd5, 1, "");
      step(1, 0, 8'h10, 0, 0, "R7 ms cleared");
      step(1, 0, 8'h08, 0, 0, "R7 seconds loaded");
      // R3 / R10: run to 999 then read ms with a tick in the same cycle
      idle(999, 1'b1);
      step(1, 0, 8'h10, 0, 1, "R10 ms at rollover");
      step(1, 0, 8'h0C, 0, 0, "R10 snapshot at rollover");
      step(1, 0, 8'h08, 0, 0, "R3 seconds carried");
      step(1, 0, 8'h10, 0, 0, "R3 ms wrapped to 0");
      // R8: writes to read-only offsets ignored
      step(1, 1, 8'h0C, 32'hDEADBEEF, 0, "");
      step(1, 1, 8'h10, 32'h123, 0, "");
      step(1, 0, 8'h0C, 0, 0, "R8 snapshot unchanged");
      step(1, 0, 8'h10, 0, 0, "R8 millis unchanged");
      // R9: unmapped offsets read zero
      step(1, 0, 8'h00, 0, 0, "R9 offset 0x00");
      step(1, 0, 8'h14, 0, 0, "R9 offset 0x14");
      // R4: seconds wrap
      step(1, 1, 8'h08, 32'hFFFF_FFFF, 0, "");
      idle(1000, 1'b1);
      step(1, 0, 8'h08, 0, 0, "R4 seconds wrapped");
      // Random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic [7:0] a;
         string req;
         r = $urandom_range(0, 99);
         case ($urandom_range(0, 4))
            0: a = 8'h08;
            1: a = 8'h0C;
            2: a = 8'h10;
            3: a = 8'h00;
            default: a = 8'h14;
         endcase
         req = (a == 8'h0C) ? "R6 snapshot read" :
               (a == 8'h10) ? "R5 millis read" : "R9 seconds/unmapped read";
         if (r < 55)      step(0, 0, 8'h00, 0, 1, "");
         else if (r < 90) step(1, 0, a, 0, logic'($urandom_range(0, 1)), req);
         else if (r < 93) step(1, 1, 8'h08, $urandom_range(0, 2000) + 32'hFFFF_F000, logic'($urandom_range(0, 1)), "");
         else             step(1, 1, (r[0] ? 8'h0C : 8'h10), $urandom, logic'($urandom_range(0, 1)), "");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule